// File: doc/BRIEF.md
# Packed Integer Media ALU

This unit performs one 64-bit packed integer operation per request. The operand pair is split either into eight unsigned 8-bit lanes or into four 16-bit lanes, depending on the opcode. The operations are:

- rounded byte average
- unsigned byte minimum and maximum
- signed word minimum and maximum
- unsigned word multiply that returns the upper half of each product
- a byte sum of absolute differences
- word extract and word insert, both selected by a 2-bit index

Most operations treat every lane on its own. The sum of absolute differences is the exception: it collapses all eight byte lanes into one scalar total.

A request is one cycle with `reqValid` high. The result is registered and appears on the next clock edge, with `resValid` high for that one cycle. Lanes are numbered from the least significant end of each operand: byte lane k is bits [8k+7:8k] and word lane k is bits [16k+15:16k].

Top module: `mediaAlu`

## Requirements
- R1: While `rstN` is low, and after reset until the first request, `resValid` is 0 and `result` is all zeros.
- R2: `resValid` is high in exactly the cycle that follows a cycle with `reqValid` high. A cycle with `reqValid` low leaves `result` unchanged.
- R3: Opcode 0 (byte average) returns, in every byte lane, (a + b + 1) >> 1. The sum is formed in 9 bits, so 0xFF averaged with 0xFF gives 0xFF.
- R4: Opcodes 1 and 2 return, in every byte lane, the unsigned minimum (opcode 1) or the unsigned maximum (opcode 2) of the two operand bytes.
- R5: Opcodes 3 and 4 return, in every word lane, the two's-complement minimum (opcode 3) or the two's-complement maximum (opcode 4) of the two operand words.
- R6: Opcode 5 returns, in every word lane, bits [31:16] of the unsigned 32-bit product of the two operand words.
- R7: Opcode 6 returns the sum of the eight byte-wise absolute differences |a - b| as a 16-bit value in `result[15:0]`. `result[63:16]` is zero.
- R8: Opcode 7 returns operand A's word lane `wordIdx`, zero-extended into `result[15:0]`. `result[63:16]` is zero.
- R9: Opcode 8 returns operand A with its word lane `wordIdx` replaced by `opB[15:0]`. All other word lanes of operand A are unchanged.
- R10: Opcodes 9 to 15 return a result of all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | A request is presented in this cycle |
| opcode | input | 4 | Operation select, codes 0 to 8 |
| wordIdx | input | 2 | Word lane index, used by extract and insert |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| resValid | output | 1 | Result register was loaded on the last edge |
| result | output | 64 | Registered packed or scalar result |

## Verification
Every opcode is driven with mixed-magnitude lanes in which the two operands win in different lanes. This shows whether the selection is made per lane or once for the whole word. Byte lanes with the top bit set tell unsigned compares apart from signed ones. Word lanes of opposite sign tell signed compares apart from unsigned ones. All-ones operands expose a lost carry in the average and in the multiply, and reach the largest possible sum of absolute differences (0x7F8). Extract and insert are run with every index value, so a lane-numbering or byte-order fault shows up. Idle cycles between requests show whether the result register is held.

// File: rtl/mediaPkg.sv
package mediaPkg;
  localparam int DATA_W = 64;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int NUM_BYTES = DATA_W / BYTE_W;
  localparam int NUM_WORDS = DATA_W / WORD_W;
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AVG_UB  = 4'd0,
    OP_MIN_UB  = 4'd1,
    OP_MAX_UB  = 4'd2,
    OP_MIN_SW  = 4'd3,
    OP_MAX_SW  = 4'd4,
    OP_MULH_UW = 4'd5,
    OP_SAD_UB  = 4'd6,
    OP_EXT_W   = 4'd7,
    OP_INS_W   = 4'd8
  } mediaOp_e;

  typedef struct packed {
    logic load;
    logic selAvg;
    logic selMinU;
    logic selMaxU;
    logic selMinS;
    logic selMaxS;
    logic selMulH;
    logic selSad;
    logic selExt;
    logic selIns;
  } mediaCtrl_t;
endpackage

// File: rtl/mediaCtrl.sv
module mediaCtrl
  import mediaPkg::*;
(
  input  logic            reqValid,
  input  logic [OP_W-1:0] opcode,
  output mediaCtrl_t      strobes
);
  always_comb begin
    strobes = '0;
    strobes.load = reqValid;
    unique case (opcode)
      OP_AVG_UB:  strobes.selAvg  = 1'b1;
      OP_MIN_UB:  strobes.selMinU = 1'b1;
      OP_MAX_UB:  strobes.selMaxU = 1'b1;
      OP_MIN_SW:  strobes.selMinS = 1'b1;
      OP_MAX_SW:  strobes.selMaxS = 1'b1;
      OP_MULH_UW: strobes.selMulH = 1'b1;
      OP_SAD_UB:  strobes.selSad  = 1'b1;
      OP_EXT_W:   strobes.selExt  = 1'b1;
      OP_INS_W:   strobes.selIns  = 1'b1;
      default:    ;
    endcase
  end
endmodule

// File: rtl/mediaDatapath.sv
module mediaDatapath
  import mediaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mediaCtrl_t        strobes,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              resValid,
  output logic [DATA_W-1:0] result
);
  localparam int SAD_W = WORD_W;

  logic [DATA_W-1:0] avgVec, minUVec, maxUVec;
  logic [DATA_W-1:0] minSVec, maxSVec, mulHVec, insVec;
  logic [BYTE_W-1:0] absDiff [NUM_BYTES];
  logic [SAD_W-1:0]  sadSum;
  logic [WORD_W-1:0] extWord;
  logic [DATA_W-1:0] nextRes;

  // Byte lanes
  for (genvar i = 0; i < NUM_BYTES; i++) begin : gByte
    logic [BYTE_W-1:0] aB, bB;
    logic [BYTE_W:0]   avgSum;
    assign aB = opA[i*BYTE_W +: BYTE_W];
    assign bB = opB[i*BYTE_W +: BYTE_W];
    assign avgSum = {1'b0, aB} + {1'b0, bB} + {{BYTE_W{1'b0}}, 1'b1};
    assign avgVec[i*BYTE_W +: BYTE_W]  = avgSum[BYTE_W:1];
    assign minUVec[i*BYTE_W +: BYTE_W] = (aB < bB) ? aB : bB;
    assign maxUVec[i*BYTE_W +: BYTE_W] = (aB > bB) ? aB : bB;
    assign absDiff[i] = (aB >= bB) ? (aB - bB) : (bB - aB);
  end

  // Word lanes
  for (genvar j = 0; j < NUM_WORDS; j++) begin : gWord
    logic [WORD_W-1:0]   aW, bW;
    logic [2*WORD_W-1:0] prod;
    logic                aLess;
    assign aW = opA[j*WORD_W +: WORD_W];
    assign bW = opB[j*WORD_W +: WORD_W];
    assign aLess = $signed(aW) < $signed(bW);
    assign prod = aW * bW;
    assign minSVec[j*WORD_W +: WORD_W] = aLess ? aW : bW;
    assign maxSVec[j*WORD_W +: WORD_W] = aLess ? bW : aW;
    assign mulHVec[j*WORD_W +: WORD_W] = prod[2*WORD_W-1:WORD_W];
    assign insVec[j*WORD_W +: WORD_W] =
      (wordIdx == IDX_W'(j)) ? opB[WORD_W-1:0] : aW;
  end

  // Reduction across byte lanes
  always_comb begin
    sadSum = '0;
    for (int k = 0; k < NUM_BYTES; k++)
      sadSum = sadSum + SAD_W'(absDiff[k]);
  end

  assign extWord = opA[wordIdx*WORD_W +: WORD_W];

  // One-hot select
  always_comb begin
    nextRes = ({DATA_W{strobes.selAvg}}  & avgVec)
            | ({DATA_W{strobes.selMinU}} & minUVec)
            | ({DATA_W{strobes.selMaxU}} & maxUVec)
            | ({DATA_W{strobes.selMinS}} & minSVec)
            | ({DATA_W{strobes.selMaxS}} & maxSVec)
            | ({DATA_W{strobes.selMulH}} & mulHVec)
            | ({DATA_W{strobes.selIns}}  & insVec);
    if (strobes.selSad) nextRes = nextRes | DATA_W'(sadSum);
    if (strobes.selExt) nextRes = nextRes | DATA_W'(extWord);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      result   <= '0;
    end else begin
      resValid <= strobes.load;
      if (strobes.load) result <= nextRes;
    end
  end
endmodule

// File: rtl/mediaAlu.sv
module mediaAlu
  import mediaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              resValid,
  output logic [DATA_W-1:0] result
);
  mediaCtrl_t strobes;

  mediaCtrl uCtrl (
    .reqValid (reqValid),
    .opcode   (opcode),
    .strobes  (strobes)
  );

  mediaDatapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wordIdx  (wordIdx),
    .opA      (opA),
    .opB      (opB),
    .resValid (resValid),
    .result   (result)
  );
endmodule

// File: rtl/mediaAluChecker.sv
module mediaAluChecker
  import mediaPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [OP_W-1:0]   opcode,
  input logic [DATA_W-1:0] opA,
  input logic              resValid,
  input logic [DATA_W-1:0] result
);
  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);
  // R2
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);
  // R2
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(result));
  // R7
  a_r7_sad_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode == 4'd6) |=> result[63:16] == '0);
  // R8
  a_r8_ext_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode == 4'd7) |=> result[63:16] == '0);
  // R10
  a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode > 4'd8) |=> result == '0);
  // R4
  a_r4_minu_not_above_a: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode == 4'd1) |=> result[7:0] <= $past(opA[7:0]));
endmodule

bind mediaAlu mediaAluChecker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .opcode   (opcode),
  .opA      (opA),
  .resValid (resValid),
  .result   (result)
);

// File: tb/tb_mediaAlu.sv
`timescale 1ns/1ps
module tb_mediaAlu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  wordIdx = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        resValid;
  logic [63:0] result;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mediaAlu dut (.*);

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  idx;
    logic [63:0] a;
    logic [63:0] b;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0, 2'd0, 64'hFF01_8000_7F10_FE00, 64'hFF02_8001_8011_0100},   // R3
    '{4'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},   // R3
    '{4'd1, 2'd0, 64'h80FF_0110_7F00_C03A, 64'h7F00_FF11_8001_3AC0},   // R4
    '{4'd2, 2'd0, 64'h80FF_0110_7F00_C03A, 64'h7F00_FF11_8001_3AC0},   // R4
    '{4'd3, 2'd0, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF},   // R5
    '{4'd4, 2'd0, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF},   // R5
    '{4'd5, 2'd0, 64'hFFFF_1234_8000_0003, 64'hFFFF_5678_0002_0005},   // R6
    '{4'd6, 2'd0, 64'h0010_FF00_0180_7F20, 64'h1000_00FF_8001_207F},   // R7
    '{4'd7, 2'd0, 64'h4444_3333_2222_1111, 64'hFFFF_FFFF_FFFF_FFFF},   // R8
    '{4'd7, 2'd1, 64'h4444_3333_2222_1111, 64'h0},                     // R8
    '{4'd7, 2'd2, 64'h4444_3333_2222_1111, 64'h0},                     // R8
    '{4'd7, 2'd3, 64'h4444_3333_2222_1111, 64'h0},                     // R8
    '{4'd8, 2'd0, 64'h4444_3333_2222_1111, 64'hAAAA_BBBB_CCCC_DDDD},   // R9
    '{4'd8, 2'd1, 64'h4444_3333_2222_1111, 64'hAAAA_BBBB_CCCC_DDDD},   // R9
    '{4'd8, 2'd2, 64'h4444_3333_2222_1111, 64'hAAAA_BBBB_CCCC_DDDD},   // R9
    '{4'd8, 2'd3, 64'h4444_3333_2222_1111, 64'hAAAA_BBBB_CCCC_DDDD},   // R9
    '{4'd9, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},   // R10
    '{4'd15,2'd3, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321}    // R10
  };

  function automatic logic [63:0] refModel(logic [3:0] op, logic [1:0] idx,
                                           logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    int sad = 0;
    for (int i = 0; i < 8; i++) begin
      int ua = int'(a[i*8 +: 8]);
      int ub = int'(b[i*8 +: 8]);
      case (op)
        4'd0: r[i*8 +: 8] = 8'((ua + ub + 1) / 2);
        4'd1: r[i*8 +: 8] = 8'((ua < ub) ? ua : ub);
        4'd2: r[i*8 +: 8] = 8'((ua > ub) ? ua : ub);
        default: ;
      endcase
      sad += (ua > ub) ? ua - ub : ub - ua;
    end
    for (int j = 0; j < 4; j++) begin
      int sa = int'($signed(a[j*16 +: 16]));
      int sb = int'($signed(b[j*16 +: 16]));
      longint pa = longint'(a[j*16 +: 16]);
      longint pb = longint'(b[j*16 +: 16]);
      longint prod = pa * pb;
      case (op)
        4'd3: r[j*16 +: 16] = 16'((sa < sb) ? sa : sb);
        4'd4: r[j*16 +: 16] = 16'((sa > sb) ? sa : sb);
        4'd5: r[j*16 +: 16] = 16'(prod >> 16);
        4'd8: r[j*16 +: 16] = (idx == 2'(j)) ? b[15:0] : a[j*16 +: 16];
        default: ;
      endcase
    end
    if (op == 4'd6) r = 64'(sad);
    if (op == 4'd7) r = {48'h0, a[idx*16 +: 16]};
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge; sample at the falling edge after capture.
  task automatic request(logic [3:0] op, logic [1:0] idx, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    reqValid = 1'b1; opcode = op; wordIdx = idx; opA = a; opB = b;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset resValid", 64'(resValid), 64'd0);
    check("R1 reset result", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {63'd0, resValid} | result, 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      request(VECS[v].op, VECS[v].idx, VECS[v].a, VECS[v].b);
      check("R2 resValid after request", 64'(resValid), 64'd1);
      check($sformatf("R3-R10 vector %0d op %0d", v, VECS[v].op), result,
            refModel(VECS[v].op, VECS[v].idx, VECS[v].a, VECS[v].b));
    end

    // R3 carry kept, hand value
    request(4'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R3 avg carry", result, 64'hFFFF_FFFF_FFFF_FFFF);
    // R7 maximum total, hand value
    request(4'd6, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    check("R7 sad max", result, 64'h0000_0000_0000_07F8);
    // R5 signed vs unsigned hand value
    request(4'd3, 2'd0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0001);
    check("R5 signed min", result, 64'h0000_0000_0000_8000);
    // R6 hand value
    request(4'd5, 2'd0, 64'h0, 64'h0000_0000_0000_FFFF | 64'h0);
    check("R6 mulh zero", result, 64'h0);

    // R2 hold across idle cycles with changing inputs
    request(4'd9, 2'd0, 64'h0, 64'h0);
    request(4'd2, 2'd0, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201);
    opcode = 4'd0; opA = '1; opB = '1;
    @(negedge clk);
    check("R2 idle resValid low", 64'(resValid), 64'd0);
    check("R2 result held", result, 64'h0807_0605_0506_0708);
    @(negedge clk);
    check("R2 result still held", result, 64'h0807_0605_0506_0708);

    // R1 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears result", result, 64'd0);
    check("R1 reset clears valid", 64'(resValid), 64'd0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule